// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small record of why a microcontroller last came out of reset. Four causes are tracked: a core power-on reset, a watchdog timeout, the external reset pin, and a system reset that software requests through the interrupt controller. Each cause arrives as a one-cycle event pulse on its own input. The block stores one sticky flag per cause, so boot firmware can read the cause after the reset is over.

Firmware reads the flags through a 32-bit register at byte offset 0x100 of a simple register port. The port has an address, a write enable, write data and combinational read data. A flag is cleared by writing a one to its bit; a zero leaves it untouched. The flag storage is initialised only by the asynchronous power-up reset. Watchdog, pin and software resets leave the storage alone. A power-on event leaves only the power-on flag standing.

Top module: `reset_cause_reg`

## Requirements
- R1: While `porRstN` is low, and after it rises with no other activity, the register reads 0x0000_0008: only the power-on flag (bit 3) is set.
- R2: A pulse on `wdtEvt` sets bit 2, on `pinEvt` sets bit 1, and on `sysEvt` sets bit 0. Each pulse sets only its own bit, and the new value is readable in the cycle after the pulse.
- R3: A write (`regWrEn` high) at address 0x100 clears every flag whose data bit in `regWrData[3:0]` is 1 and leaves every flag whose data bit is 0 unchanged. With `regWrEn` low, nothing is cleared.
- R4: When an event pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: A pulse on `porEvt` leaves the flags at exactly 0x8 in the following cycle. This holds whatever the prior state, and whatever events or writes arrive in the same cycle.
- R6: Bits 31 to 4 always read as 0, and writing ones to them has no effect.
- R7: A read at any address other than 0x100 returns 0, and a write at any other address changes no flag.
- R8: When no event, no matching write and no power-up reset occur, every flag holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-up reset of the flag storage, active low |
| porEvt | input | 1 | One-cycle pulse: power-on reset occurred |
| wdtEvt | input | 1 | One-cycle pulse: watchdog reset occurred |
| pinEvt | input | 1 | One-cycle pulse: external pin reset occurred |
| sysEvt | input | 1 | One-cycle pulse: software system reset occurred |
| regAddr | input | 12 | Register byte address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data; ones clear flags |
| regRdData | output | 32 | Read data for the addressed register |

## Verification
A hardware set and a firmware write-1 clear can land on the same flag in the same clock. A power-on event can also coincide with other events and with a clearing write. The bench provokes both cases by driving the event pulse and the register write in a single cycle. It then reads the register on the next cycle and expects the set to survive the clear, and the power-on event to override everything and leave 0x8. A behavioural model of the flags is also compared with the read data on every clock.

// File: rtl/reset_cause_pkg.sv
package reset_cause_pkg;

  localparam int unsigned NUM_CAUSES = 4;

  // Bit positions inside the status register; firmware decodes these.
  localparam int unsigned BIT_SYS = 0;
  localparam int unsigned BIT_PIN = 1;
  localparam int unsigned BIT_WDT = 2;
  localparam int unsigned BIT_POR = 3;

  typedef logic [NUM_CAUSES-1:0] cause_vec_t;

  localparam cause_vec_t POR_ONLY = cause_vec_t'(1) << BIT_POR;

  // Strobes from the decode logic to the flag datapath.
  typedef struct packed {
    logic       regSel;   // address matches the status register
    cause_vec_t clrMask;  // write-one-to-clear mask for this cycle
  } ctrl_strobe_t;

endpackage

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
  import reset_cause_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'('h100)
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output ctrl_strobe_t      strobe
);

  logic addrHit;

  assign addrHit = (regAddr == REG_OFFSET);

  always_comb begin
    strobe.regSel  = addrHit;
    strobe.clrMask = '0;
    if (addrHit && regWrEn) begin
      // Only the low flag bits are writable; reserved bits are dropped here.
      strobe.clrMask = regWrData[NUM_CAUSES-1:0];
    end
  end

endmodule

// File: rtl/reset_cause_flags.sv
module reset_cause_flags
  import reset_cause_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              porEvt,
  input  logic              wdtEvt,
  input  logic              pinEvt,
  input  logic              sysEvt,
  input  ctrl_strobe_t      strobe,
  output logic [DATA_W-1:0] rdData
);

  localparam int unsigned PAD_W = DATA_W - NUM_CAUSES;

  cause_vec_t setVec;
  cause_vec_t flagQ;
  cause_vec_t flagD;

  always_comb begin
    setVec          = '0;
    setVec[BIT_WDT] = wdtEvt;
    setVec[BIT_PIN] = pinEvt;
    setVec[BIT_SYS] = sysEvt;
  end

  // Power-on dominates; otherwise the set is applied after the clear so it wins.
  always_comb begin
    if (porEvt) flagD = POR_ONLY;
    else        flagD = (flagQ & ~strobe.clrMask) | setVec;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) flagQ <= POR_ONLY;
    else          flagQ <= flagD;
  end

  always_comb begin
    rdData = '0;
    if (strobe.regSel) rdData = {{PAD_W{1'b0}}, flagQ};
  end

  // R5
  por_leaves_only_own_chk: assert property (@(posedge clk) disable iff (!porRstN)
    porEvt |=> (flagQ == POR_ONLY));

  for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_bitChk
    // R4
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!porRstN)
      (!porEvt && setVec[i]) |=> flagQ[i]);
    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!porRstN)
      (!porEvt && strobe.clrMask[i] && !setVec[i]) |=> !flagQ[i]);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!porRstN)
      (!porEvt && !strobe.clrMask[i] && !setVec[i]) |=> (flagQ[i] == $past(flagQ[i])));
  end

endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import reset_cause_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'('h100)
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              porEvt,
  input  logic              wdtEvt,
  input  logic              pinEvt,
  input  logic              sysEvt,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);

  ctrl_strobe_t strobe;

  reset_cause_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)
  ) u_ctrl (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .strobe   (strobe)
  );

  reset_cause_flags #(
    .DATA_W(DATA_W)
  ) u_flags (
    .clk    (clk),
    .porRstN(porRstN),
    .porEvt (porEvt),
    .wdtEvt (wdtEvt),
    .pinEvt (pinEvt),
    .sysEvt (sysEvt),
    .strobe (strobe),
    .rdData (regRdData)
  );

endmodule

// File: tb/reset_cause_reg_test.sv
`timescale 1ns/100ps
module reset_cause_reg_test;

  localparam logic [11:0] REG_ADDR = 12'h100;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        porEvt = 1'b0, wdtEvt = 1'b0, pinEvt = 1'b0, sysEvt = 1'b0;
  logic [11:0] regAddr = REG_ADDR;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int model = 8;

  always #2.5 clk = ~clk;

  reset_cause_reg uut (
    .clk(clk), .porRstN(porRstN), .porEvt(porEvt), .wdtEvt(wdtEvt),
    .pinEvt(pinEvt), .sysEvt(sysEvt), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  // Behavioural reference of the four flags.
  always @(posedge clk or negedge porRstN) begin
    int clr, setv;
    if (!porRstN) model = 8;
    else if (porEvt) model = 8;
    else begin
      clr  = (regWrEn && regAddr == REG_ADDR) ? int'(regWrData[3:0]) : 0;
      setv = (wdtEvt ? 4 : 0) + (pinEvt ? 2 : 0) + (sysEvt ? 1 : 0);
      model = (model & ~clr & 15) | setv;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R8 hold, plus every other rule).
  always @(negedge clk) begin
    if (!done) check("R8", regRdData, (regAddr == REG_ADDR) ? 32'(model) : 32'h0);
  end

  task automatic idle();
    porEvt = 0; wdtEvt = 0; pinEvt = 0; sysEvt = 0;
    regWrEn = 0; regWrData = '0; regAddr = REG_ADDR;
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // One cycle of stimulus, then back to idle.
  task automatic drive(bit p, bit w, bit pn, bit s, bit we, logic [11:0] a, logic [31:0] d);
    step();
    porEvt = p; wdtEvt = w; pinEvt = pn; sysEvt = s;
    regWrEn = we; regAddr = a; regWrData = d;
    step();
    idle();
    #0.5;
  endtask

  task automatic readAt(string req, logic [11:0] a, logic [31:0] exp);
    regAddr = a; #0.5;
    check(req, regRdData, exp);
    regAddr = REG_ADDR; #0.5;
  endtask

  initial begin
    idle();
    porRstN = 0;
    #3; readAt("R1", REG_ADDR, 32'h8);
    repeat (3) @(posedge clk);
    step(); porRstN = 1;
    step(); readAt("R1", REG_ADDR, 32'h8);
    readAt("R7", 12'h104, 32'h0);
    readAt("R7", 12'h000, 32'h0);

    drive(0,0,0,0,1,REG_ADDR,32'h8);  readAt("R3", REG_ADDR, 32'h0);
    drive(0,1,0,0,0,REG_ADDR,0);      readAt("R2", REG_ADDR, 32'h4);
    drive(0,0,0,0,1,REG_ADDR,32'hF);  readAt("R3", REG_ADDR, 32'h0);
    drive(0,0,1,0,0,REG_ADDR,0);      readAt("R2", REG_ADDR, 32'h2);
    drive(0,0,0,0,1,REG_ADDR,32'hF);
    drive(0,0,0,1,0,REG_ADDR,0);      readAt("R2", REG_ADDR, 32'h1);
    drive(0,1,1,0,0,REG_ADDR,0);      readAt("R2", REG_ADDR, 32'h7);
    drive(0,0,0,0,1,REG_ADDR,32'h2);  readAt("R3", REG_ADDR, 32'h5);
    drive(0,0,0,0,1,REG_ADDR,32'hFFFF_FFF0); readAt("R6", REG_ADDR, 32'h5);
    drive(0,0,0,0,1,12'h104,32'hF);   readAt("R7", REG_ADDR, 32'h5);
    drive(0,0,0,0,0,REG_ADDR,32'hF);  readAt("R3", REG_ADDR, 32'h5);
    repeat (4) step();                readAt("R8", REG_ADDR, 32'h5);

    drive(0,0,0,0,1,REG_ADDR,32'hF);  readAt("R3", REG_ADDR, 32'h0);
    drive(0,0,0,1,1,REG_ADDR,32'hF);  readAt("R4", REG_ADDR, 32'h1);
    drive(0,1,1,0,1,REG_ADDR,32'h6);  readAt("R4", REG_ADDR, 32'h7);

    drive(1,0,0,0,0,REG_ADDR,0);      readAt("R5", REG_ADDR, 32'h8);
    drive(0,1,0,1,0,REG_ADDR,0);      readAt("R2", REG_ADDR, 32'hD);
    drive(1,1,1,1,1,REG_ADDR,32'hF);  readAt("R5", REG_ADDR, 32'h8);
    drive(0,0,0,0,1,REG_ADDR,32'h8);  readAt("R3", REG_ADDR, 32'h0);
    drive(1,0,0,0,0,REG_ADDR,0);      readAt("R5", REG_ADDR, 32'h8);

    drive(0,1,1,1,0,REG_ADDR,0);      readAt("R2", REG_ADDR, 32'hF);
    step(); porRstN = 0; #0.5;        readAt("R1", REG_ADDR, 32'h8);
    step(); porRstN = 1;
    step();                           readAt("R1", REG_ADDR, 32'h8);

    repeat (2) step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule